// File: doc/BRIEF.md
# Keyboard Command Responder Queue

This block stands in for the remote end of a serial keyboard link. The host side of a serial channel hands it command bytes. For each command it knows, the block answers by loading a fixed multi-byte reply into a small receive queue. The host then pulls that reply out one byte per read strobe. A byte-available flag tells the channel's receive-ready logic that data is waiting. After every read that leaves bytes behind, a one-cycle re-arm pulse asks the channel to raise receive-ready again.

Each reply-producing command first discards whatever is still queued and then loads its whole script in a single cycle. One command only latches an LED-mode flag, and every other command value is ignored. The queue keeps separate read and write pointers that wrap at the depth. A fresh reply starts wherever the write pointer stands, so the storage is used as a ring over time.

Top module: `kbd_cmd_responder`

## Requirements
- R1: A strobed command 0x01 empties the queue and loads 0xFF, 0x04, 0x7F, in that order. `byte_avail` is 1 in the following cycle.
- R2: A strobed command 0x0E sets `led_mode` in the following cycle and leaves the queue contents unchanged. `led_mode` stays set until reset.
- R3: A strobed command 0x07 or 0x0F empties the queue and loads 0xFE then 0x00.
- R4: A strobed command with any value other than 0x01, 0x07, 0x0E or 0x0F leaves the queue contents and `led_mode` unchanged.
- R5: A read strobe on a non-empty queue puts the oldest byte on `rd_data` in the following cycle and removes it from the queue. `byte_avail` is 1 exactly while the queue holds at least one byte. `rd_data` holds its value between reads.
- R6: A read strobe on an empty queue gives `rd_data` = 0x00 in the following cycle.
- R7: `rearm` is 1 for exactly one cycle after a read strobe, and only when the queue still holds at least one byte after that read.
- R8: The byte count never exceeds `DEPTH`. Bytes beyond the depth in a single load are dropped.
- R9: While `rst_n` is low at a clock edge, the queue empties and `led_mode`, `rd_data` and `rearm` go to 0.
- R10: When a command and a read strobe fall in the same cycle, the read returns the head byte from before the command. A reply-producing command replaces the queue, and that read removes no byte from the new reply. For any other command, the read removes the head normally.
- R11: Reply order stays correct when the read and write pointers wrap past the last entry, as happens after many replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one byte per cycle |
| cmd_byte | input | 8 | Command value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| byte_avail | output | 1 | Queue holds at least one byte |
| rearm | output | 1 | One-cycle request to re-raise receive-ready |
| led_mode | output | 1 | Latched LED-mode flag |

## Verification
The assertions check several rules on every cycle: the count bound, the exact fill level after each reply-producing command, the one-byte decrement on a plain read, zero returned from an empty read, LED-flag stickiness, count stability under unknown commands, and that a re-arm pulse is only seen with data present. The actual byte values and their order only show up through the bench's scenarios. So do a command and a read landing in the same cycle, and correct ordering once the pointers have wrapped; those need a reference queue holding the expected contents.

// File: rtl/kbd_resp_pkg.sv
// Shared types and constants for the keyboard command responder.
// Assumes 8-bit command and reply bytes.
package kbd_resp_pkg;

    localparam int BYTE_W     = 8;
    localparam int SCRIPT_MAX = 3;
    localparam int SCRIPT_LW  = $clog2(SCRIPT_MAX + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [BYTE_W-1:0] {
        KCMD_RESET    = 8'h01,
        KCMD_LAYOUT_A = 8'h07,
        KCMD_LED      = 8'h0E,
        KCMD_LAYOUT_B = 8'h0F
    } kbd_cmd_e;

    // What one command asks of the queue and the LED flag.
    typedef struct packed {
        logic                         load;
        logic                         led_set;
        logic [SCRIPT_LW-1:0]         len;
        byte_t [SCRIPT_MAX-1:0]       bytes;
    } reply_plan_t;

endpackage

// File: rtl/kbd_reply_script.sv
// Turns a strobed command byte into a reply plan: whether to reload
// the queue, with how many bytes and which, and whether to set the
// LED flag. Purely combinational; unknown values give an empty plan.
module kbd_reply_script
    import kbd_resp_pkg::*;
(
    input  logic        cmd_valid,
    input  byte_t       cmd_byte,
    output reply_plan_t plan
);

    // Map each known command to its fixed reply script.
    always_comb begin
        plan = '0;
        if (cmd_valid) begin
            case (cmd_byte)
                KCMD_RESET: begin
                    plan.load     = 1'b1;
                    plan.len      = SCRIPT_LW'(3);
                    plan.bytes[0] = 8'hFF;
                    plan.bytes[1] = 8'h04;
                    plan.bytes[2] = 8'h7F;
                end
                KCMD_LAYOUT_A, KCMD_LAYOUT_B: begin
                    plan.load     = 1'b1;
                    plan.len      = SCRIPT_LW'(2);
                    plan.bytes[0] = 8'hFE;
                    plan.bytes[1] = 8'h00;
                end
                KCMD_LED: begin
                    plan.led_set  = 1'b1;
                end
                default: plan = '0;
            endcase
        end
    end

endmodule

// File: rtl/kbd_reply_fifo.sv
// Ring queue with a bulk-load port. A load discards the current
// contents (read pointer jumps to write pointer) and writes up to
// LOAD_MAX bytes starting at the write pointer in one cycle; bytes
// beyond DEPTH are dropped. A pop removes the head when not empty.
// Load wins over a simultaneous pop. Assumes DEPTH is a power of two.
module kbd_reply_fifo #(
    parameter int DEPTH    = 16,
    parameter int LOAD_MAX = 3,
    parameter int W        = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int LW      = $clog2(LOAD_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [LW-1:0]                load_len,
    input  logic [LOAD_MAX-1:0][W-1:0]   load_bytes,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [CW-1:0]                count,
    output logic [CW-1:0]                count_next
);

    localparam int KEEP = (LOAD_MAX < DEPTH) ? LOAD_MAX : DEPTH;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr;
    logic [AW-1:0] wptr;
    logic [CW-1:0] accept_len;
    logic [AW-1:0] wr_idx [KEEP];

    // Slot address for each byte of a bulk load, wrapping at DEPTH.
    for (genvar g = 0; g < KEEP; g++) begin : g_widx
        assign wr_idx[g] = wptr + AW'(g);
    end

    // Number of load bytes kept after the depth limit.
    always_comb begin
        if (int'(load_len) > DEPTH) accept_len = CW'(DEPTH);
        else                        accept_len = CW'(load_len);
    end

    // Next fill level: load replaces, pop decrements when non-empty.
    always_comb begin
        if (load)                    count_next = accept_len;
        else if (pop && count != '0) count_next = count - CW'(1);
        else                         count_next = count;
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            count <= count_next;
            if (load) begin
                rptr <= wptr;
                wptr <= wptr + AW'(accept_len);
            end else if (pop && count != '0) begin
                rptr <= rptr + AW'(1);
            end
        end
    end

    // Storage: write the accepted bytes of a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < KEEP; i++) begin
                if (i < int'(accept_len)) mem[wr_idx[i]] <= load_bytes[i];
            end
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/kbd_cmd_responder.sv
// Keyboard command responder: decodes command bytes into reply
// scripts, queues the reply, serves host reads one byte at a time,
// pulses rearm while bytes remain and latches the LED-mode flag.
// Assumes at most one command and one read strobe per cycle.
module kbd_cmd_responder #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       byte_avail,
    output logic       rearm,
    output logic       led_mode
);
    import kbd_resp_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    reply_plan_t   plan;
    byte_t         head;
    logic [CW-1:0] fifo_count;
    logic [CW-1:0] fifo_count_next;
    byte_t         rd_data_q;
    logic          rearm_q;
    logic          led_q;

    kbd_reply_script u_script (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .plan      (plan)
    );

    kbd_reply_fifo #(
        .DEPTH    (DEPTH),
        .LOAD_MAX (SCRIPT_MAX),
        .W        (BYTE_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (plan.load),
        .load_len   (plan.len),
        .load_bytes (plan.bytes),
        .pop        (rd_en),
        .head       (head),
        .count      (fifo_count),
        .count_next (fifo_count_next)
    );

    // Latch the LED-mode flag; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)            led_q <= 1'b0;
        else if (plan.led_set) led_q <= 1'b1;
    end

    // Capture the head byte on a read, zero when the queue is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data_q <= '0;
        else if (rd_en) rd_data_q <= (fifo_count != '0) ? head : '0;
    end

    // One-cycle re-arm request when bytes remain after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rearm_q <= 1'b0;
        else        rearm_q <= rd_en && (fifo_count_next != '0);
    end

    assign rd_data    = rd_data_q;
    assign rearm      = rearm_q;
    assign led_mode   = led_q;
    assign byte_avail = (fifo_count != '0);

endmodule

// File: rtl/kbd_cmd_responder_chk.sv
// Property checker for kbd_cmd_responder, bound to every instance.
// Assumes the command encodings listed in the requirements.
module kbd_cmd_responder_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [7:0]    cmd_byte,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          byte_avail,
    input logic          rearm,
    input logic          led_mode,
    input logic [CW-1:0] fifo_count
);

    logic known_cmd;
    assign known_cmd = (cmd_byte == 8'h01) || (cmd_byte == 8'h07) ||
                       (cmd_byte == 8'h0E) || (cmd_byte == 8'h0F);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    assert_reset_reply_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == 8'h01 |=> fifo_count == CW'(3));

    assert_layout_reply_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_byte == 8'h07 || cmd_byte == 8'h0F) |=> fifo_count == CW'(2));

    assert_led_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == 8'h0E |=> led_mode);

    assert_led_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        led_mode |=> led_mode);

    assert_ignored_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !known_cmd && !rd_en |=> $stable(fifo_count));

    assert_pop_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !cmd_valid && fifo_count != '0 |=> fifo_count == $past(fifo_count) - CW'(1));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !cmd_valid && fifo_count == '0 |=> rd_data == 8'h00);

    assert_rearm_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |-> byte_avail);

endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .byte_avail (byte_avail),
    .rearm      (rearm),
    .led_mode   (led_mode),
    .fifo_count (fifo_count)
);

// File: tb/sim_kbd_cmd_responder.sv
`timescale 1ns/1ps
// Bench: behavioural queue model updated every clock and compared
// against all outputs after each edge.
module sim_kbd_cmd_responder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       byte_avail;
    logic       rearm;
    logic       led_mode;

    int checks   = 0;
    int failures = 0;
    string cur_req = "R9";

    byte unsigned mq[$];
    logic [7:0] m_rd;
    logic       m_rearm;
    logic       m_led;

    always #4 clk = ~clk;

    kbd_cmd_responder #(.DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rd_en(rd_en), .rd_data(rd_data), .byte_avail(byte_avail),
        .rearm(rearm), .led_mode(led_mode)
    );

    task automatic check1(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", cur_req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare after it.
    task automatic cyc(logic cv, logic [7:0] cb, logic rd, logic rs = 1'b1);
        @(negedge clk);
        rst_n = rs; cmd_valid = cv; cmd_byte = cb; rd_en = rd;
        @(posedge clk);
        #1;
        if (!rs) begin
            mq.delete(); m_rd = 8'h00; m_rearm = 1'b0; m_led = 1'b0;
        end else begin
            if (rd) m_rd = (mq.size() > 0) ? mq[0] : 8'h00;
            if (cv && cb == 8'h01) begin
                mq.delete(); mq.push_back(8'hFF); mq.push_back(8'h04); mq.push_back(8'h7F);
            end else if (cv && (cb == 8'h07 || cb == 8'h0F)) begin
                mq.delete(); mq.push_back(8'hFE); mq.push_back(8'h00);
            end else if (rd && mq.size() > 0) begin
                void'(mq.pop_front());
            end
            if (cv && cb == 8'h0E) m_led = 1'b1;
            m_rearm = rd && (mq.size() > 0);
        end
        check1("rd_data", rd_data, m_rd);
        check1("byte_avail", {7'd0, byte_avail}, {7'd0, mq.size() > 0});
        check1("rearm", {7'd0, rearm}, {7'd0, m_rearm});
        check1("led_mode", {7'd0, led_mode}, {7'd0, m_led});
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00; rd_en = 1'b0;
        m_rd = 8'h00; m_rearm = 1'b0; m_led = 1'b0;
        // R9: reset state
        cur_req = "R9";
        repeat (3) cyc(1'b0, 8'h00, 1'b0, 1'b0);
        // R6: read from empty queue
        cur_req = "R6";
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        // R1 with R5/R7: reset reply drained, then one empty read
        cur_req = "R1";
        cyc(1'b1, 8'h01, 1'b0);
        cur_req = "R5";
        repeat (4) cyc(1'b0, 8'h00, 1'b1);
        cur_req = "R7";
        cyc(1'b0, 8'h00, 1'b0);
        // R3: both layout queries
        cur_req = "R3";
        cyc(1'b1, 8'h07, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        cyc(1'b1, 8'h0F, 1'b0);
        repeat (3) cyc(1'b0, 8'h00, 1'b1);
        // R2: LED command leaves queue alone
        cur_req = "R2";
        cyc(1'b1, 8'h01, 1'b0);
        cyc(1'b1, 8'h0E, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        // R4: unknown commands ignored
        cur_req = "R4";
        cyc(1'b1, 8'h02, 1'b0);
        cyc(1'b1, 8'hFF, 1'b0);
        cyc(1'b1, 8'h00, 1'b0);
        repeat (3) cyc(1'b0, 8'h00, 1'b1);
        // R10: command and read in the same cycle
        cur_req = "R10";
        cyc(1'b1, 8'h01, 1'b0);
        cyc(1'b1, 8'h07, 1'b1);
        cyc(1'b1, 8'h0E, 1'b1);
        cyc(1'b1, 8'h55, 1'b1);
        cyc(1'b0, 8'h00, 1'b1);
        // R11 and R8: many replies so both pointers wrap repeatedly
        cur_req = "R11";
        for (int k = 0; k < 30; k++) begin
            cyc(1'b1, (k % 3 == 0) ? 8'h0F : 8'h01, 1'b0);
            for (int j = 0; j < (k % 4); j++) cyc(1'b0, 8'h00, 1'b1);
        end
        repeat (4) cyc(1'b0, 8'h00, 1'b1);
        // R9: reset mid-operation clears queue and LED flag
        cur_req = "R9";
        cyc(1'b1, 8'h01, 1'b0);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        cyc(1'b0, 8'h00, 1'b0);
        cyc(1'b0, 8'h00, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule